// File: doc/BRIEF.md
# Dithered PWM Channel Comparator

This block produces one pulse-width-modulated output from a bank of shared free-running timers. A channel selects one of four timer counts and compares it every clock against a programmed rising point and a derived falling point. The pin goes high when the count reaches the rising point. It goes low when the count reaches the rising point plus the whole-number part of a fixed-point duty word.

The duty word carries four fractional bits. A 4-bit phase accumulator adds the fraction once per period. In each period where the addition carries, the falling point moves one count later. Over any 16 consecutive periods, the stretched periods therefore number exactly the fractional value, which gives sub-count average resolution.

The rising point and the duty word are written into staging registers. They are copied into the active set only at the selected timer's overflow strobe, so a period is never cut short. The selection, enable and idle-level fields apply at once. The timers, any fade sequencing and the bus decode sit outside this block. A simple write port (enable, 2-bit address, data) stands in for the bus.

Top module: `pwm_dither_chan`

## Requirements
- R1: After reset, `pwm_o` is 0 and `duty_o` is 0. Reset clears the enable and sets the idle level to 0.
- R2: Control register (address 0): bits [1:0] select timer 0..3 (code 00 selects timer 0, up to code 11 for timer 3), bit 4 enables the output, and bit 5 is the idle level. A write applies from the next clock. Only the selected timer's count and overflow strobe affect the channel.
- R3: When the selected count equals the active rising point (address 1, bits [19:0]), `pwm_o` is 1 from the following clock.
- R4: When the selected count equals the active rising point plus the duty integer (duty bits [24:4], address 2), plus one in a stretched period, `pwm_o` is 0 from the following clock. The high time is therefore integer+stretch cycles.
- R5: With duty fraction f (bits [3:0]), every period has a high time of either the integer or the integer plus one. Any 16 consecutive periods contain exactly f stretched ones.
- R6: Staged rising-point and duty writes become active only at the selected timer's overflow strobe, which is high during the last count of a period. `duty_o` shows the active duty and changes only after such a strobe. A write in the same clock as the strobe misses that boundary and takes effect one period later.
- R7: If the active falling point equals the rising point (duty 0), the output stays low for the whole period.
- R8: With the enable bit clear, `pwm_o` holds the idle level whatever the comparison does.
- R9: A write to address 3 changes nothing: not the output waveform and not `duty_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tmr_cnt_i | input | 80 | Four 20-bit timer counts; timer k occupies bits [20k+19:20k] |
| tmr_ovf_i | input | 4 | Per-timer overflow strobe, high during the last count of a period |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_addr_i | input | 2 | Register address: 0 control, 1 rising point, 2 duty |
| cfg_wdata_i | input | 32 | Write data |
| pwm_o | output | 1 | PWM pin |
| duty_o | output | 25 | Duty word currently in effect |

## Verification
Two events can fall in the same clock: a configuration write and the selected timer's overflow strobe. The bench provokes this by driving a duty write during the last count of a period. It then checks that `duty_o` keeps the old value across that boundary and takes the new value only at the following one.

The falling-point and rising-point comparisons can also hit the same count. This is forced with a zero duty, and every period is expected to show zero high cycles.

// File: rtl/pwm_dither_pkg.sv
package pwm_dither_pkg;
  typedef enum logic [1:0] {
    REG_CTL  = 2'd0,
    REG_HP   = 2'd1,
    REG_DUTY = 2'd2
  } reg_addr_e;

  localparam int unsigned CTL_EN_BIT   = 4;
  localparam int unsigned CTL_IDLE_BIT = 5;
endpackage

// File: rtl/pwm_cnt_mux.sv
module pwm_cnt_mux #(
  parameter int unsigned CNT_W = 20,
  parameter int unsigned N_TMR = 4,
  parameter int unsigned SEL_W = 2
) (
  input  logic [N_TMR*CNT_W-1:0] cnt_i,
  input  logic [N_TMR-1:0]       ovf_i,
  input  logic [SEL_W-1:0]       sel_i,
  output logic [CNT_W-1:0]       cnt_o,
  output logic                   ovf_o
);
  logic [CNT_W-1:0] cnt_arr [N_TMR];

  for (genvar k = 0; k < N_TMR; k++) begin : g_unpack
    assign cnt_arr[k] = cnt_i[k*CNT_W +: CNT_W];
  end

  assign cnt_o = cnt_arr[sel_i];
  assign ovf_o = ovf_i[sel_i];
endmodule

// File: rtl/pwm_cfg_stage.sv
module pwm_cfg_stage
  import pwm_dither_pkg::*;
#(
  parameter int unsigned CNT_W  = 20,
  parameter int unsigned INT_W  = 21,
  parameter int unsigned FRAC_W = 4,
  parameter int unsigned SEL_W  = 2,
  parameter int unsigned DAT_W  = 32,
  localparam int unsigned DUTY_W = INT_W + FRAC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [DAT_W-1:0]  wdata_i,
  input  logic              ovf_i,
  output logic [SEL_W-1:0]  sel_o,
  output logic              en_o,
  output logic              idle_o,
  output logic [CNT_W-1:0]  hp_act_o,
  output logic [DUTY_W-1:0] duty_act_o,
  output logic [DUTY_W-1:0] duty_stg_o,
  output logic              extra_o
);
  logic [CNT_W-1:0]  hp_stg;
  logic [FRAC_W-1:0] phase_q;
  logic [FRAC_W:0]   phase_sum;
  logic              unused_wdata;

  assign unused_wdata = ^wdata_i;

  // carry out of the phase accumulator marks a stretched period
  assign phase_sum = {1'b0, phase_q} + {1'b0, duty_stg_o[FRAC_W-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_o      <= '0;
      en_o       <= 1'b0;
      idle_o     <= 1'b0;
      hp_stg     <= '0;
      duty_stg_o <= '0;
      hp_act_o   <= '0;
      duty_act_o <= '0;
      phase_q    <= '0;
      extra_o    <= 1'b0;
    end else begin
      if (we_i) begin
        case (reg_addr_e'(addr_i))
          REG_CTL: begin
            sel_o  <= wdata_i[SEL_W-1:0];
            en_o   <= wdata_i[CTL_EN_BIT];
            idle_o <= wdata_i[CTL_IDLE_BIT];
          end
          REG_HP:   hp_stg     <= wdata_i[CNT_W-1:0];
          REG_DUTY: duty_stg_o <= wdata_i[DUTY_W-1:0];
          default: ;
        endcase
      end
      if (ovf_i) begin
        hp_act_o   <= hp_stg;
        duty_act_o <= duty_stg_o;
        phase_q    <= phase_sum[FRAC_W-1:0];
        extra_o    <= phase_sum[FRAC_W];
      end
    end
  end
endmodule

// File: rtl/pwm_cmp_out.sv
module pwm_cmp_out #(
  parameter int unsigned CNT_W = 20,
  parameter int unsigned LP_W  = 23
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] hp_i,
  input  logic [LP_W-1:0]  lp_i,
  output logic             pwm_q_o
);
  logic [LP_W-1:0] cnt_ext;

  assign cnt_ext = LP_W'(cnt_i);

  // low point wins so that lp == hp keeps the pin low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             pwm_q_o <= 1'b0;
    else if (cnt_ext == lp_i) pwm_q_o <= 1'b0;
    else if (cnt_i == hp_i)   pwm_q_o <= 1'b1;
  end
endmodule

// File: rtl/pwm_dither_chan.sv
module pwm_dither_chan #(
  parameter int unsigned CNT_W  = 20,
  parameter int unsigned N_TMR  = 4,
  parameter int unsigned INT_W  = 21,
  parameter int unsigned FRAC_W = 4,
  parameter int unsigned DAT_W  = 32,
  localparam int unsigned DUTY_W = INT_W + FRAC_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_TMR*CNT_W-1:0] tmr_cnt_i,
  input  logic [N_TMR-1:0]       tmr_ovf_i,
  input  logic                   cfg_we_i,
  input  logic [1:0]             cfg_addr_i,
  input  logic [DAT_W-1:0]       cfg_wdata_i,
  output logic                   pwm_o,
  output logic [DUTY_W-1:0]      duty_o
);
  localparam int unsigned SEL_W = (N_TMR > 1) ? $clog2(N_TMR) : 1;
  localparam int unsigned LP_W  = ((CNT_W > INT_W) ? CNT_W : INT_W) + 2;

  logic [SEL_W-1:0]  sel;
  logic              en, idle;
  logic [CNT_W-1:0]  cnt_sel;
  logic              ovf_sel;
  logic [CNT_W-1:0]  hp_act;
  logic [DUTY_W-1:0] duty_stg;
  logic              extra;
  logic [LP_W-1:0]   lp_pt;
  logic              pwm_q;

  pwm_cnt_mux #(.CNT_W(CNT_W), .N_TMR(N_TMR), .SEL_W(SEL_W)) u_mux (
    .cnt_i (tmr_cnt_i),
    .ovf_i (tmr_ovf_i),
    .sel_i (sel),
    .cnt_o (cnt_sel),
    .ovf_o (ovf_sel)
  );

  pwm_cfg_stage #(
    .CNT_W(CNT_W), .INT_W(INT_W), .FRAC_W(FRAC_W), .SEL_W(SEL_W), .DAT_W(DAT_W)
  ) u_stage (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .addr_i     (cfg_addr_i),
    .wdata_i    (cfg_wdata_i),
    .ovf_i      (ovf_sel),
    .sel_o      (sel),
    .en_o       (en),
    .idle_o     (idle),
    .hp_act_o   (hp_act),
    .duty_act_o (duty_o),
    .duty_stg_o (duty_stg),
    .extra_o    (extra)
  );

  assign lp_pt = LP_W'(hp_act) + LP_W'(duty_o[DUTY_W-1:FRAC_W]) + LP_W'(extra);

  pwm_cmp_out #(.CNT_W(CNT_W), .LP_W(LP_W)) u_cmp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cnt_i   (cnt_sel),
    .hp_i    (hp_act),
    .lp_i    (lp_pt),
    .pwm_q_o (pwm_q)
  );

  assign pwm_o = en ? pwm_q : idle;
endmodule

// File: rtl/pwm_dither_chan_chk.sv
module pwm_dither_chan_chk #(
  parameter int unsigned CNT_W  = 20,
  parameter int unsigned DUTY_W = 25,
  parameter int unsigned LP_W   = 23
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ovf_sel,
  input logic [CNT_W-1:0]  cnt_sel,
  input logic [CNT_W-1:0]  hp_act,
  input logic [LP_W-1:0]   lp_pt,
  input logic              pwm_q,
  input logic [DUTY_W-1:0] duty_o,
  input logic [DUTY_W-1:0] duty_stg
);
  a_r6_duty_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ovf_sel |=> $stable(duty_o));

  a_r6_duty_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_sel |=> duty_o == $past(duty_stg));

  a_r3_rise_at_hp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwm_q) |-> $past(cnt_sel) == $past(hp_act));

  a_r4_fall_at_lp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pwm_q) |-> LP_W'($past(cnt_sel)) == $past(lp_pt));

  a_r7_zero_duty_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lp_pt == LP_W'(hp_act)) && !pwm_q |=> !pwm_q);
endmodule

bind pwm_dither_chan pwm_dither_chan_chk #(
  .CNT_W(CNT_W), .DUTY_W(DUTY_W), .LP_W(LP_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ovf_sel  (ovf_sel),
  .cnt_sel  (cnt_sel),
  .hp_act   (hp_act),
  .lp_pt    (lp_pt),
  .pwm_q    (pwm_q),
  .duty_o   (duty_o),
  .duty_stg (duty_stg)
);

// File: tb/pwm_dither_chan_tb_top.sv
`timescale 1ns/1ps
module pwm_dither_chan_tb_top;
  localparam int CNT_W = 20;
  localparam int N_TMR = 4;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [N_TMR*CNT_W-1:0] tmr_cnt;
  logic [N_TMR-1:0]  tmr_ovf;
  logic              cfg_we = 1'b0;
  logic [1:0]        cfg_addr = '0;
  logic [31:0]       cfg_wdata = '0;
  logic              pwm_o;
  logic [24:0]       duty_o;

  logic [CNT_W-1:0]  tcnt [N_TMR];
  int n_chk = 0;
  int n_fail = 0;
  int cur_sel = 0;
  int mon_acc = 0;
  int meas_q[$];

  always #2.5 clk_i = ~clk_i;

  function automatic int per_of(int k);
    return 40 + 12 * k;
  endfunction

  for (genvar k = 0; k < N_TMR; k++) begin : g_tmr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) tcnt[k] <= '0;
      else if (int'(tcnt[k]) == per_of(k) - 1) tcnt[k] <= '0;
      else tcnt[k] <= tcnt[k] + 1'b1;
    end
    assign tmr_cnt[k*CNT_W +: CNT_W] = tcnt[k];
    assign tmr_ovf[k] = (int'(tcnt[k]) == per_of(k) - 1);
  end

  pwm_dither_chan dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tmr_cnt_i   (tmr_cnt),
    .tmr_ovf_i   (tmr_ovf),
    .cfg_we_i    (cfg_we),
    .cfg_addr_i  (cfg_addr),
    .cfg_wdata_i (cfg_wdata),
    .pwm_o       (pwm_o),
    .duty_o      (duty_o)
  );

  // monitor: high cycles per period of the selected timer
  always @(negedge clk_i) begin
    if (rst_ni) begin
      mon_acc += int'(pwm_o);
      if (tcnt[cur_sel] == '0) begin
        meas_q.push_back(mon_acc);
        mon_acc = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_now(input logic [1:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk_i);
    cfg_we = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wr_now(a, d);
  endtask

  task automatic wait_cnt(input int v);
    do @(negedge clk_i); while (int'(tcnt[cur_sel]) != v);
  endtask

  task automatic align();
    wait_cnt(2);
    wait_cnt(0);
    #0.1;
    meas_q.delete();
  endtask

  task automatic pop_w(output int w);
    wait (meas_q.size() > 0);
    w = meas_q.pop_front();
  endtask

  task automatic edges(input int h, input int l, input string req);
    wait_cnt(h);     chk(pwm_o == 1'b0, req, int'(pwm_o), 0);
    wait_cnt(h + 1); chk(pwm_o == 1'b1, req, int'(pwm_o), 1);
    wait_cnt(l);     chk(pwm_o == 1'b1, req, int'(pwm_o), 1);
    wait_cnt(l + 1); chk(pwm_o == 1'b0, req, int'(pwm_o), 0);
  endtask

  task automatic widths_fixed(input int n, input int exp, input string req);
    int w;
    for (int i = 0; i < n; i++) begin
      pop_w(w);
      chk(w == exp, req, w, exp);
    end
  endtask

  task automatic widths_dither(input int d, input int f, input string req);
    int w, n_up, n_bad;
    n_up = 0; n_bad = 0;
    for (int i = 0; i < 16; i++) begin
      pop_w(w);
      if (w == d + 1) n_up++;
      else if (w != d) n_bad++;
    end
    chk(n_bad == 0, req, n_bad, 0);
    chk(n_up == f, req, n_up, f);
  endtask

  function automatic logic [31:0] ctl(int sel, bit en, bit idle);
    return 32'(sel) | (32'(en) << 4) | (32'(idle) << 5);
  endfunction

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int bad;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(pwm_o == 1'b0, "R1", int'(pwm_o), 0);
    chk(duty_o == '0, "R1", int'(duty_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(pwm_o == 1'b0 && duty_o == '0, "R1", int'(pwm_o), 0);

    // R8 disabled output follows idle level
    wr(2'd1, 32'd5);
    wr(2'd2, 32'(10 << 4));
    wr(2'd0, ctl(0, 1'b0, 1'b1));
    align();
    bad = 0;
    repeat (80) begin @(negedge clk_i); if (pwm_o != 1'b1) bad++; end
    chk(bad == 0, "R8 idle high", bad, 0);
    wr(2'd0, ctl(0, 1'b0, 1'b0));
    bad = 0;
    repeat (80) begin @(negedge clk_i); if (pwm_o != 1'b0) bad++; end
    chk(bad == 0, "R8 idle low", bad, 0);

    // R3 R4 timer 0
    wr(2'd0, ctl(0, 1'b1, 1'b0));
    align();
    edges(5, 15, "R3 R4 t0");
    widths_fixed(3, 10, "R4 t0 width");

    // R2 switch to timer 2
    wr(2'd1, 32'd30);
    wr(2'd2, 32'(20 << 4));
    wr(2'd0, ctl(2, 1'b1, 1'b0));
    cur_sel = 2;
    align();
    edges(30, 50, "R2 t2 edges");
    widths_fixed(3, 20, "R2 t2 width");

    // R5 dither on timer 1
    wr(2'd1, 32'd4);
    wr(2'd2, 32'((12 << 4) | 5));
    wr(2'd0, ctl(1, 1'b1, 1'b0));
    cur_sel = 1;
    align();
    widths_dither(12, 5, "R5 frac5");
    wr(2'd2, 32'((12 << 4) | 15));
    align();
    widths_dither(12, 15, "R5 frac15");

    // R7 zero duty
    wr(2'd1, 32'd8);
    wr(2'd2, 32'd0);
    align();
    widths_fixed(3, 0, "R7 zero duty");

    // R6 staged duty
    wait_cnt(3);
    wr_now(2'd2, 32'((7 << 4) | 3));
    chk(duty_o == 25'd0, "R6 before ovf", int'(duty_o), 0);
    wait_cnt(0);
    chk(duty_o == 25'd115, "R6 after ovf", int'(duty_o), 115);
    // R6 write colliding with overflow
    wait_cnt(per_of(1) - 1);
    wr_now(2'd2, 32'd192);
    chk(duty_o == 25'd115, "R6 collide old", int'(duty_o), 115);
    wait_cnt(1);
    wait_cnt(0);
    chk(duty_o == 25'd192, "R6 collide new", int'(duty_o), 192);

    // R9 address 3 ignored
    wr(2'd3, 32'h01FF_FFFF);
    align();
    chk(duty_o == 25'd192, "R9 duty", int'(duty_o), 192);
    widths_fixed(2, 12, "R9 width");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule